// File: doc/BRIEF.md
# Multi-Clock Frequency Counter

This block measures how fast several unrelated clocks run compared with the clock of the register bus that controls it. Counter 0 runs on the bus clock and acts as the reference. Each measured clock has its own counter, clocked by that clock. Software sets an enable bit in the control register and clears it again some time later. That single enable is synchronized into every clock domain, so all counters count across the same interval. When the interval is over, software reads the counts and finds each frequency as reference frequency × measured count ÷ reference count. This relies on the bus clock running at exactly its nominal rate.

Each counter sends its value back to the bus domain through a toggle request/acknowledge handshake. The bus side keeps a snapshot of every counter. A status flag tells software when every snapshot holds a value captured after the last control write. The control register also has a clear bit, which zeroes every counter and overflow flag. Counters stop at all-ones instead of wrapping, and each one raises its own overflow flag when it saturates.

Top module: `clk_rate_meter`

## Requirements
- R1: After reset, the control register reads 0, every counter snapshot reads 0, and all overflow flags read 0.
- R2: The control register is at offset 0. Bit 0 is the enable and bit 1 is the clear. A write stores bit 0 as written. It stores bit 1 only when bit 0 of the same write is 0, and otherwise stores 0. Reads return the stored bits.
- R3: The reference counter (index 0, offset 2) increases by exactly the number of bus-clock cycles during which the stored enable bit was 1.
- R4: The counter for measured clock k (index k+1, offset 3+k) counts edges of its own clock over the enable interval. The result is within ±2 of the reference count scaled by the ratio of that clock's frequency to the bus clock frequency.
- R5: While the enable is 0 and the clear is 0, no counter changes. Successive enable intervals add to the counts that are already there.
- R6: When the clear bit is 1 and the enable is 0, every counter and every overflow flag goes to 0. A write that sets both bits clears nothing.
- R7: A counter that reaches 2^CNT_W−1 stays there. Its overflow flag (status bit 1+index) goes to 1 on the next enabled edge of its clock.
- R8: Status bit 0 reads 1 only when the enable is 0 and every domain has completed a snapshot capture that began after the most recent control write. It reads 0 while the enable is set.
- R9: Status is at offset 1. Counter i is at offset 2+i. All other offsets read 0, and writes to any offset other than 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register-bus clock; also the reference clock |
| busRstN | input | 1 | Active-low asynchronous reset for all domains |
| measClk | input | NUM_MEAS | Clocks to be measured |
| wrEn | input | 1 | Write strobe for one bus cycle |
| addr | input | ADDR_W | Register offset for reads and writes |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr`, combinational |

## Verification
A control write changes the stored bits at the clock edge where it is taken, and readback shows the change in the next cycle. A counter responds to a new enable or clear two edges of its own clock later. A snapshot reaches the bus side only after a full round trip of the handshake, which costs two synchronizer stages in each direction. Because of this, the scoreboard never expects a count at a fixed cycle. The driver first polls status bit 0 until it reads 1, and only then queues the expected counts. Each queued read is sampled one nanosecond after the bus edge that follows the address change, when the combinational read path has settled.

// File: rtl/crm_pkg.sv
package crm_pkg;
  typedef struct packed {
    logic enable;
    logic clear;
    logic restart;
  } crmStrobes_t;
endpackage

// File: rtl/crm_sync2.sv
module crm_sync2 (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= 1'b0;
      q      <= 1'b0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/crm_ctrl.sv
module crm_ctrl
  import crm_pkg::*;
#(
  parameter int NUM_CLK = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                     busClk,
  input  logic                     busRstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  output crmStrobes_t              strobes,
  input  logic [NUM_CLK*CNT_W-1:0] snapCounts,
  input  logic [NUM_CLK-1:0]       snapOvf,
  input  logic [NUM_CLK-1:0]       domValid
);
  localparam logic [ADDR_W-1:0] CTRL_OFS   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(1);
  localparam int                COUNT_BASE = 2;

  logic ctrlEn;
  logic ctrlClr;
  logic ctrlWr;
  logic statusValid;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:2];
  assign ctrlWr       = wrEn && (addr == CTRL_OFS);

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      ctrlEn  <= 1'b0;
      ctrlClr <= 1'b0;
    end else if (ctrlWr) begin
      ctrlEn  <= wrData[0];
      ctrlClr <= wrData[1] & ~wrData[0];
    end
  end

  assign strobes.enable  = ctrlEn;
  assign strobes.clear   = ctrlClr;
  assign strobes.restart = ctrlWr;

  assign statusValid = (&domValid) && !ctrlEn;

  always_comb begin
    rdData = '0;
    if (addr == CTRL_OFS) begin
      rdData[1:0] = {ctrlClr, ctrlEn};
    end else if (addr == STATUS_OFS) begin
      rdData[0]         = statusValid;
      rdData[NUM_CLK:1] = snapOvf;
    end else begin
      for (int k = 0; k < NUM_CLK; k++) begin
        if (addr == ADDR_W'(k + COUNT_BASE)) begin
          rdData[CNT_W-1:0] = snapCounts[k*CNT_W +: CNT_W];
        end
      end
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge busClk) disable iff (!busRstN)
    ctrlWr |=> (ctrlEn == $past(wrData[0]))); // R2

  AST_VALID_NEEDS_IDLE: assert property (@(posedge busClk) disable iff (!busRstN)
    (ctrlWr && wrData[0]) |=> (rdData[0] == 1'b0 || addr != STATUS_OFS)); // R8
endmodule

// File: rtl/crm_datapath.sv
module crm_datapath
  import crm_pkg::*;
#(
  parameter int NUM_MEAS = 2,
  parameter int CNT_W    = 32
) (
  input  logic                               busClk,
  input  logic                               busRstN,
  input  logic [NUM_MEAS-1:0]                measClk,
  input  crmStrobes_t                        strobes,
  output logic [(NUM_MEAS+1)*CNT_W-1:0]      snapCounts,
  output logic [NUM_MEAS:0]                  snapOvf,
  output logic [NUM_MEAS:0]                  domValid
);
  localparam int NUM_CLK = NUM_MEAS + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CLK-1:0] domClk;
  assign domClk = {measClk, busClk};

  for (genvar g = 0; g < NUM_CLK; g++) begin : gDom
    // destination-domain state
    logic             enS;
    logic             clrS;
    logic             reqS;
    logic [CNT_W-1:0] cnt;
    logic             ovf;
    logic [CNT_W-1:0] holdCnt;
    logic             holdOvf;
    logic             ackTog;
    // bus-domain state
    logic             reqTog;
    logic             ackS;
    logic             ackSeen;
    logic             kicked;
    logic             stale;
    logic             valid;
    logic [CNT_W-1:0] snap;
    logic             snapO;

    crm_sync2 enSync_i  (.clk(domClk[g]), .rstN(busRstN), .d(strobes.enable), .q(enS));
    crm_sync2 clrSync_i (.clk(domClk[g]), .rstN(busRstN), .d(strobes.clear),  .q(clrS));
    crm_sync2 reqSync_i (.clk(domClk[g]), .rstN(busRstN), .d(reqTog),         .q(reqS));
    crm_sync2 ackSync_i (.clk(busClk),    .rstN(busRstN), .d(ackTog),         .q(ackS));

    always_ff @(posedge domClk[g] or negedge busRstN) begin
      if (!busRstN) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (clrS && !enS) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (enS) begin
        if (cnt == CNT_MAX) ovf <= 1'b1;
        else                cnt <= cnt + 1'b1;
      end
    end

    always_ff @(posedge domClk[g] or negedge busRstN) begin
      if (!busRstN) begin
        holdCnt <= '0;
        holdOvf <= 1'b0;
        ackTog  <= 1'b0;
      end else if (reqS != ackTog) begin
        holdCnt <= cnt;
        holdOvf <= ovf;
        ackTog  <= reqS;
      end
    end

    always_ff @(posedge busClk or negedge busRstN) begin
      if (!busRstN) begin
        reqTog  <= 1'b0;
        ackSeen <= 1'b0;
        kicked  <= 1'b0;
        stale   <= 1'b0;
        valid   <= 1'b0;
        snap    <= '0;
        snapO   <= 1'b0;
      end else if (!kicked) begin
        kicked <= 1'b1;
        reqTog <= ~reqTog;
        stale  <= strobes.restart;
      end else if (ackS != ackSeen) begin
        ackSeen <= ackS;
        snap    <= holdCnt;
        snapO   <= holdOvf;
        valid   <= !stale && !strobes.restart;
        stale   <= strobes.restart;
        reqTog  <= ~reqTog;
      end else if (strobes.restart) begin
        stale <= 1'b1;
        valid <= 1'b0;
      end
    end

    assign snapCounts[g*CNT_W +: CNT_W] = snap;
    assign snapOvf[g]  = snapO;
    assign domValid[g] = valid;

    AST_IDLE_HOLD: assert property (@(posedge domClk[g]) disable iff (!busRstN)
      (!enS && !clrS) |=> $stable(cnt)); // R5

    AST_CLR_ZERO: assert property (@(posedge domClk[g]) disable iff (!busRstN)
      (clrS && !enS) |=> (cnt == '0 && !ovf)); // R6

    AST_SAT_HOLD: assert property (@(posedge domClk[g]) disable iff (!busRstN)
      (cnt == CNT_MAX && !(clrS && !enS)) |=> (cnt == CNT_MAX)); // R7

    AST_RESTART_INVALID: assert property (@(posedge busClk) disable iff (!busRstN)
      strobes.restart |=> !valid); // R8
  end
endmodule

// File: rtl/clk_rate_meter.sv
module clk_rate_meter
  import crm_pkg::*;
#(
  parameter int NUM_MEAS = 2,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic                busClk,
  input  logic                busRstN,
  input  logic [NUM_MEAS-1:0] measClk,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData
);
  localparam int NUM_CLK = NUM_MEAS + 1;

  crmStrobes_t              strobes;
  logic [NUM_CLK*CNT_W-1:0] snapCounts;
  logic [NUM_CLK-1:0]       snapOvf;
  logic [NUM_CLK-1:0]       domValid;

  crm_ctrl #(
    .NUM_CLK(NUM_CLK), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .busClk(busClk), .busRstN(busRstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .strobes(strobes),
    .snapCounts(snapCounts), .snapOvf(snapOvf), .domValid(domValid)
  );

  crm_datapath #(
    .NUM_MEAS(NUM_MEAS), .CNT_W(CNT_W)
  ) datapath_i (
    .busClk(busClk), .busRstN(busRstN), .measClk(measClk), .strobes(strobes),
    .snapCounts(snapCounts), .snapOvf(snapOvf), .domValid(domValid)
  );
endmodule

// File: tb/clk_rate_meter_tb_top.sv
module clk_rate_meter_tb_top;
  localparam int NUM_MEAS = 2;
  localparam int CNT_W    = 10;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;

  logic                busClk = 1'b0;
  logic                busRstN = 1'b0;
  logic                mClkSlow = 1'b0;
  logic                mClkFast = 1'b0;
  logic [NUM_MEAS-1:0] measClk;
  logic                wrEn = 1'b0;
  logic [ADDR_W-1:0]   addr = '0;
  logic [DATA_W-1:0]   wrData = '0;
  logic [DATA_W-1:0]   rdData;

  always #2 busClk   = ~busClk;   // 250 MHz reference
  always #4 mClkSlow = ~mClkSlow; // 125 MHz, ratio 1/2
  always #1 mClkFast = ~mClkFast; // 500 MHz, ratio 2
  assign measClk = {mClkFast, mClkSlow};

  clk_rate_meter #(
    .NUM_MEAS(NUM_MEAS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dut_i (
    .busClk(busClk), .busRstN(busRstN), .measClk(measClk), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] e;
    int                tol;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // driver side: queue an expected read value, then wait for the monitor
  task automatic expectReg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                           input int tol, input string tag);
    expItem_t it;
    @(negedge busClk);
    addr = a;
    it.a = a; it.e = e; it.tol = tol; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  // monitor side: sample just after the edge following the address change
  initial begin
    forever begin
      @(posedge busClk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        longint diff;
        it = expQ.pop_front();
        diff = longint'(rdData) - longint'(it.e);
        if (diff < 0) diff = -diff;
        vectors++;
        if (diff > longint'(it.tol)) begin
          miscompares++;
          $display("FAIL %s: offset %0d actual=%0d expected=%0d (tol %0d)",
                   it.tag, it.a, rdData, it.e, it.tol);
        end
      end
    end
  end

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge busClk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge busClk);
    wrEn = 1'b0;
  endtask

  // enable bit held for exactly n bus cycles
  task automatic runWindow(input int n, input logic [DATA_W-1:0] code);
    @(negedge busClk);
    wrEn = 1'b1; addr = '0; wrData = code;
    @(negedge busClk);
    wrEn = 1'b0;
    repeat (n - 1) @(negedge busClk);
    wrEn = 1'b1; wrData = '0;
    @(negedge busClk);
    wrEn = 1'b0;
  endtask

  task automatic waitValid();
    bit seen;
    seen = 1'b0;
    @(negedge busClk);
    addr = ADDR_W'(1);
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge busClk);
      if (rdData[0]) seen = 1'b1;
    end
  endtask

  task automatic clearAll();
    writeReg(ADDR_W'(0), 32'd2);
    repeat (10) @(negedge busClk);
    expectReg(ADDR_W'(0), 32'd2, 0, "R2 clear bit readback");
    writeReg(ADDR_W'(0), 32'd0);
  endtask

  task automatic expectCounts(input int r, input int s, input int f, input string tag);
    expectReg(ADDR_W'(2), DATA_W'(r), 0, {tag, " R3 reference"});
    expectReg(ADDR_W'(3), DATA_W'(s), 2, {tag, " R4 slow clock"});
    expectReg(ADDR_W'(4), DATA_W'(f), 2, {tag, " R4 fast clock"});
  endtask

  initial begin
    repeat (5) @(negedge busClk);
    busRstN = 1'b1;

    // R1 reset state
    expectReg(ADDR_W'(0), 32'd0, 0, "R1 control after reset");
    expectReg(ADDR_W'(2), 32'd0, 0, "R1 count0 after reset");
    expectReg(ADDR_W'(3), 32'd0, 0, "R1 count1 after reset");
    expectReg(ADDR_W'(4), 32'd0, 0, "R1 count2 after reset");
    waitValid();
    expectReg(ADDR_W'(1), 32'd1, 0, "R1 status valid, no overflow");

    // R8/R2 while enabled
    writeReg(ADDR_W'(0), 32'd1);
    expectReg(ADDR_W'(1), 32'd0, 0, "R8 status low while enabled");
    expectReg(ADDR_W'(0), 32'd1, 0, "R2 enable readback");
    writeReg(ADDR_W'(0), 32'd0);
    clearAll();
    waitValid();
    expectCounts(0, 0, 0, "R6 after clear");

    // main measurement
    runWindow(200, 32'd1);
    waitValid();
    expectReg(ADDR_W'(1), 32'd1, 0, "R8 valid after window");
    expectCounts(200, 100, 400, "window 200");

    // R5 accumulate, and idle hold
    repeat (50) @(negedge busClk);
    expectCounts(200, 100, 400, "R5 idle hold");
    runWindow(100, 32'd1);
    waitValid();
    expectCounts(300, 150, 600, "R5 accumulate");

    // R6/R2 clear together with enable is ignored
    runWindow(50, 32'd3);
    waitValid();
    expectCounts(350, 175, 700, "R6 clear with enable ignored");

    // R9 writes to other offsets and unmapped reads
    writeReg(ADDR_W'(1), 32'hFFFF_FFFF);
    writeReg(ADDR_W'(3), 32'd0);
    writeReg(ADDR_W'(9), 32'h3);
    expectReg(ADDR_W'(0), 32'd0, 0, "R9 control untouched");
    expectReg(ADDR_W'(1), 32'd1, 0, "R9 status untouched");
    expectReg(ADDR_W'(3), 32'd175, 2, "R9 count untouched");
    expectReg(ADDR_W'(9), 32'd0, 0, "R9 unmapped reads zero");

    clearAll();
    waitValid();
    expectCounts(0, 0, 0, "R6 cleared");

    // R7 saturation of the fast counter (bit 3 = overflow of index 2)
    runWindow(600, 32'd1);
    waitValid();
    expectCounts(600, 300, 1023, "R7 saturation");
    expectReg(ADDR_W'(1), 32'd9, 0, "R7 overflow flag index 2");

    clearAll();
    waitValid();
    expectReg(ADDR_W'(1), 32'd1, 0, "R6 overflow cleared");
    expectReg(ADDR_W'(4), 32'd0, 0, "R6 saturated count cleared");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge busClk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL R8 watchdog: actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule